// File: doc/BRIEF.md
# Tristate-Buffered Parallel Port Controller

This block provides 24 general-purpose parallel lines behind a small byte-wide register interface. The lines form four direction groups: two full byte ports (A and B) and a third byte port (C) split into a low and a high nibble. Each group is set to input or output on its own. Output values are held in latches. Input values are never latched, so a port read always shows the live line state.

A single control byte does two jobs. When its top bit is written high, the byte loads a new direction setting and also sets a buffer-disable latch that turns off every line driver. When its top bit is written low, only the buffer-disable latch is cleared and the drivers come back on. Software can therefore choose the directions, preset the output values while nothing is driven, and then release the drivers in one step. The lines have external pull-ups, so a line that nobody drives reads as 1.

Top module: `par_port_ctrl`

## Requirements
- R1: A write to offset 0, 1 or 2 loads the output latch of port A, B or C at the write edge. The latch is visible on `pin_out` from the next cycle. `pin_out` bits 7:0 carry A, bits 15:8 carry B and bits 23:16 carry C. For C, data bits 3:0 feed the low nibble (lines 19:16) and data bits 7:4 feed the high nibble (lines 23:20).
- R2: A write to offset 3 with data bit 7 set stores data bits 6:0 as the new configuration and sets the buffer-disable latch. In the configuration, bit 4 gives the direction of A, bit 1 of B, bit 0 of the C low nibble and bit 3 of the C high nibble, with 1 meaning input. From the next cycle `pin_oe` is all zero.
- R3: A write to offset 3 with data bit 7 clear clears the buffer-disable latch and leaves the stored configuration unchanged, whatever data bits 6:0 hold.
- R4: A line's `pin_oe` bit is 1 exactly when its group is configured as output and the buffer-disable latch is clear.
- R5: Output latches accept writes while the buffers are disabled or the group is an input. The stored value is driven once the group is an output and the buffers are enabled.
- R6: A read of offset 0, 1 or 2 returns the live `pin_in` byte of that port in the same cycle, also for ports set to output.
- R7: A read of offset 3 returns the buffer-disable latch in bit 7 and the stored configuration bits 6:0 below it.
- R8: After reset every group is an input, the buffer-disable latch is clear, `pin_oe` is all zero, the output latches hold 0, and a read of offset 3 returns 0x1B. An undriven, pulled-up line reads as 1.
- R9: Port writes and all reads leave the direction configuration, the buffer-disable latch and `pin_oe` unchanged.
- R10: Configuration bits 2, 5 and 6 (the unsupported handshake mode selection) are stored and read back, and they have no effect on any direction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 2 | Register offset: 0 = A, 1 = B, 2 = C, 3 = control |
| reg_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| reg_wdata | input | BYTE_W | Write data |
| reg_rdata | output | BYTE_W | Read data for `reg_addr`, combinational |
| pin_in | input | 3*BYTE_W | Live line state from the pads |
| pin_out | output | 3*BYTE_W | Output latch values toward the pads |
| pin_oe | output | 3*BYTE_W | Per-line driver enable |

## Verification
Every register write takes effect at the clock edge that samples it. The new `pin_out` and `pin_oe` values, and the control read-back, are therefore due one cycle after the strobe is applied. Reads are combinational and are due in the same cycle that `reg_addr` is applied. The bench drives its inputs just after a rising edge and compares against a behavioural model on the falling edge. The model updates its state on the same rising edge as the design, so every comparison looks at the cycle in which the result must already be present. The pads are modelled in the bench, so port reads are checked against live line values that include the pull-ups and the bench's own external drivers.

// File: rtl/ppc_pkg.sv
package ppc_pkg;

   typedef enum logic [1:0] {
      SEL_PA  = 2'd0,
      SEL_PB  = 2'd1,
      SEL_PC  = 2'd2,
      SEL_CTL = 2'd3
   } reg_sel_e;

   localparam int NUM_GRP  = 4;
   localparam int CTL_W    = 8;
   localparam int OFF_BIT  = 7;
   localparam int CFG_W    = CTL_W - 1;
   localparam logic [CFG_W-1:0] CFG_RESET = 7'h1B;

   // group order: 0 = A, 1 = B, 2 = C low nibble, 3 = C high nibble
   function automatic int grp_dir_bit(input int g);
      case (g)
         0:       return 4;
         1:       return 1;
         2:       return 0;
         default: return 3;
      endcase
   endfunction

   function automatic int grp_width(input int g, input int bw);
      return (g < 2) ? bw : bw / 2;
   endfunction

   function automatic int grp_pin_lo(input int g, input int bw);
      case (g)
         0:       return 0;
         1:       return bw;
         2:       return 2 * bw;
         default: return 2 * bw + bw / 2;
      endcase
   endfunction

   function automatic int grp_data_lo(input int g, input int bw);
      return (g == 3) ? bw / 2 : 0;
   endfunction

   function automatic logic [1:0] grp_reg(input int g);
      case (g)
         0:       return SEL_PA;
         1:       return SEL_PB;
         default: return SEL_PC;
      endcase
   endfunction

endpackage

// File: rtl/ppc_ctl_reg.sv
module ppc_ctl_reg
   import ppc_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_ctl,
   input  logic [CTL_W-1:0] wdata,
   output logic [CFG_W-1:0] cfg_q,
   output logic             buf_off
);

   logic load_cfg;
   logic en_buf;

   assign load_cfg = wr_ctl &  wdata[OFF_BIT];
   assign en_buf   = wr_ctl & ~wdata[OFF_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= CFG_RESET;
      end else if (load_cfg) begin
         cfg_q <= wdata[CFG_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         buf_off <= 1'b0;
      end else if (load_cfg) begin
         buf_off <= 1'b1;
      end else if (en_buf) begin
         buf_off <= 1'b0;
      end
   end

endmodule

// File: rtl/ppc_out_latch.sv
module ppc_out_latch #(
   parameter int          W   = 8,
   parameter logic [W-1:0] RST = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (W < 1) begin : g_bad_w
      $error("ppc_out_latch: W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= RST;
      end else if (we) begin
         q <= d;
      end
   end

endmodule

// File: rtl/ppc_drv_gate.sv
module ppc_drv_gate #(
   parameter int W             = 8,
   parameter bit HOLD_WHEN_OFF = 1'b1
) (
   input  logic         dir_in,
   input  logic         buf_off,
   input  logic [W-1:0] lat_q,
   output logic [W-1:0] drv_val,
   output logic [W-1:0] drv_en
);

   logic drive;

   assign drive  = ~dir_in & ~buf_off;
   assign drv_en = {W{drive}};

   if (HOLD_WHEN_OFF) begin : g_hold
      assign drv_val = lat_q;
   end else begin : g_park
      assign drv_val = drive ? lat_q : '0;
   end

endmodule

// File: rtl/ppc_rd_mux.sv
module ppc_rd_mux
   import ppc_pkg::*;
#(
   parameter int BYTE_W = 8,
   localparam int PIN_W = 3 * BYTE_W
) (
   input  logic [1:0]        addr,
   input  logic [PIN_W-1:0]  pin_in,
   input  logic [CFG_W-1:0]  cfg_q,
   input  logic              buf_off,
   output logic [BYTE_W-1:0] rdata
);

   always_comb begin
      rdata = '0;
      case (reg_sel_e'(addr))
         SEL_PA:  rdata = pin_in[BYTE_W-1:0];
         SEL_PB:  rdata = pin_in[2*BYTE_W-1:BYTE_W];
         SEL_PC:  rdata = pin_in[3*BYTE_W-1:2*BYTE_W];
         default: rdata[CTL_W-1:0] = {buf_off, cfg_q};
      endcase
   end

endmodule

// File: rtl/par_port_ctrl.sv
module par_port_ctrl
   import ppc_pkg::*;
#(
   parameter int                  BYTE_W        = 8,
   parameter logic [3*BYTE_W-1:0] OUT_RST       = '0,
   parameter bit                  HOLD_WHEN_OFF = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [1:0]            reg_addr,
   input  logic                  reg_wr,
   input  logic [BYTE_W-1:0]     reg_wdata,
   output logic [BYTE_W-1:0]     reg_rdata,
   input  logic [3*BYTE_W-1:0]   pin_in,
   output logic [3*BYTE_W-1:0]   pin_out,
   output logic [3*BYTE_W-1:0]   pin_oe
);

   localparam int PIN_W = 3 * BYTE_W;

   if (BYTE_W < CTL_W || (BYTE_W % 2) != 0) begin : g_bad_bw
      $error("par_port_ctrl: BYTE_W must be even and at least 8");
   end

   logic [CFG_W-1:0] cfg_q;
   logic             buf_off;
   logic             wr_ctl;

   assign wr_ctl = reg_wr && (reg_addr == SEL_CTL);

   ppc_ctl_reg u_ctl (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_ctl  (wr_ctl),
      .wdata   (reg_wdata[CTL_W-1:0]),
      .cfg_q   (cfg_q),
      .buf_off (buf_off)
   );

   for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
      localparam int GW  = grp_width(g, BYTE_W);
      localparam int PLO = grp_pin_lo(g, BYTE_W);
      localparam int DLO = grp_data_lo(g, BYTE_W);
      localparam int DB  = grp_dir_bit(g);

      logic          we;
      logic [GW-1:0] lat_q;

      assign we = reg_wr && (reg_addr == grp_reg(g));

      ppc_out_latch #(
         .W   (GW),
         .RST (OUT_RST[PLO +: GW])
      ) u_lat (
         .clk   (clk),
         .rst_n (rst_n),
         .we    (we),
         .d     (reg_wdata[DLO +: GW]),
         .q     (lat_q)
      );

      ppc_drv_gate #(
         .W             (GW),
         .HOLD_WHEN_OFF (HOLD_WHEN_OFF)
      ) u_drv (
         .dir_in  (cfg_q[DB]),
         .buf_off (buf_off),
         .lat_q   (lat_q),
         .drv_val (pin_out[PLO +: GW]),
         .drv_en  (pin_oe[PLO +: GW])
      );
   end

   ppc_rd_mux #(
      .BYTE_W (BYTE_W)
   ) u_rd (
      .addr    (reg_addr),
      .pin_in  (pin_in),
      .cfg_q   (cfg_q),
      .buf_off (buf_off),
      .rdata   (reg_rdata)
   );

endmodule

// File: rtl/ppc_chk.sv
module ppc_chk #(
   parameter int BYTE_W = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic [1:0]          reg_addr,
   input logic                reg_wr,
   input logic [BYTE_W-1:0]   reg_wdata,
   input logic [BYTE_W-1:0]   reg_rdata,
   input logic [3*BYTE_W-1:0] pin_in,
   input logic [3*BYTE_W-1:0] pin_out,
   input logic [3*BYTE_W-1:0] pin_oe,
   input logic [6:0]          cfg_q,
   input logic                buf_off
);

   // R2
   ctl_tristate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == 2'd3 && reg_wdata[7]) |=> (pin_oe == '0));

   // R3
   ctl_keep_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == 2'd3 && !reg_wdata[7]) |=> (cfg_q == $past(cfg_q) && !buf_off));

   // R1
   pa_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == 2'd0) |=> (pin_out[BYTE_W-1:0] == $past(reg_wdata)));

   // R9
   port_wr_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr != 2'd3) |=> $stable(pin_oe));

   // R6
   pa_live_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == 2'd0) |-> (reg_rdata == pin_in[BYTE_W-1:0]));

   // R4
   off_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      buf_off |-> (pin_oe == '0));

endmodule

bind par_port_ctrl ppc_chk #(.BYTE_W(BYTE_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_addr  (reg_addr),
   .reg_wr    (reg_wr),
   .reg_wdata (reg_wdata),
   .reg_rdata (reg_rdata),
   .pin_in    (pin_in),
   .pin_out   (pin_out),
   .pin_oe    (pin_oe),
   .cfg_q     (cfg_q),
   .buf_off   (buf_off)
);

// File: tb/tb_par_port_ctrl.sv
module tb_par_port_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic        reg_wr = 1'b0;
   logic [7:0]  reg_wdata = 8'h00;
   logic [7:0]  reg_rdata;
   logic [23:0] pin_in, pin_out, pin_oe;
   logic [23:0] ext_en = '0, ext_val = '0;

   int total = 0, bad = 0, cyc = 0;
   bit done = 0, model_on = 0;

   always #4 clk = ~clk;

   // pads: driver wins, then external source, else pull-up
   assign pin_in = (pin_oe & pin_out) | (~pin_oe & ((ext_en & ext_val) | ~ext_en));

   par_port_ctrl dut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
   );

   // behavioural reference
   int m_cfg, m_off;
   logic [7:0] m_a, m_b, m_c;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cfg = 'h1B; m_off = 0; m_a = 0; m_b = 0; m_c = 0;
      end else if (reg_wr) begin
         case (reg_addr)
            2'd0: m_a = reg_wdata;
            2'd1: m_b = reg_wdata;
            2'd2: m_c = reg_wdata;
            default: begin
               if (reg_wdata[7]) begin m_cfg = reg_wdata & 'h7F; m_off = 1; end
               else m_off = 0;
            end
         endcase
      end
   end

   function automatic logic [23:0] exp_oe();
      logic [23:0] e = '0;
      if (m_off == 0) begin
         if (((m_cfg >> 4) & 1) == 0) e[7:0]   = 8'hFF;
         if (((m_cfg >> 1) & 1) == 0) e[15:8]  = 8'hFF;
         if ((m_cfg & 1) == 0)        e[19:16] = 4'hF;
         if (((m_cfg >> 3) & 1) == 0) e[23:20] = 4'hF;
      end
      return e;
   endfunction

   function automatic logic [7:0] exp_rd(input logic [1:0] a);
      logic [23:0] oe = exp_oe();
      logic [23:0] o  = {m_c, m_b, m_a};
      logic [23:0] p  = (oe & o) | (~oe & ((ext_en & ext_val) | ~ext_en));
      case (a)
         2'd0: return p[7:0];
         2'd1: return p[15:8];
         2'd2: return p[23:16];
         default: return {m_off[0], m_cfg[6:0]};
      endcase
   endfunction

   task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   // per-cycle model comparison
   always @(negedge clk) begin
      if (rst_n && model_on) begin
         check("R4 oe", pin_oe, exp_oe());
         check("R1 out", pin_out, {m_c, m_b, m_a});
         check(reg_addr == 2'd3 ? "R7 ctl rd" : "R6 port rd", {16'h0, reg_rdata}, {16'h0, exp_rd(reg_addr)});
      end
   end

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(posedge clk); #1;
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(posedge clk); #1;
      reg_wr = 1'b0;
   endtask

   task automatic rd_expect(input logic [1:0] a, input logic [7:0] e, input string req);
      @(posedge clk); #1;
      reg_addr = a;
      @(negedge clk);
      check(req, {16'h0, reg_rdata}, {16'h0, e});
   endtask

   task automatic oe_expect(input logic [23:0] e, input string req);
      @(negedge clk);
      check(req, pin_oe, e);
   endtask

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 50000 && !done) begin
         bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         summary();
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      model_on = 1;
      // R8 reset state
      rd_expect(2'd3, 8'h1B, "R8 ctl after reset");
      oe_expect(24'h000000, "R8 oe after reset");
      rd_expect(2'd0, 8'hFF, "R8 pull-up read");
      check("R8 out after reset", pin_out, 24'h0);
      // R6 live input
      ext_en = 24'h0000FF; ext_val = 24'h00005A;
      rd_expect(2'd0, 8'h5A, "R6 input A live");
      // R5 preset while input
      wr(2'd0, 8'h3C);
      oe_expect(24'h000000, "R5 preset while input");
      // R2 config with drivers off
      wr(2'd3, 8'h80);
      oe_expect(24'h000000, "R2 tristate after 0x80");
      rd_expect(2'd3, 8'h80, "R7 ctl reads 0x80");
      wr(2'd1, 8'hA5);
      wr(2'd2, 8'h96);
      rd_expect(2'd0, 8'h5A, "R6 tristated output reads pad");
      // enable
      wr(2'd3, 8'h00);
      oe_expect(24'hFFFFFF, "R4 all outputs driven");
      rd_expect(2'd0, 8'h3C, "R5 preset A driven");
      rd_expect(2'd2, 8'h96, "R5 preset C driven");
      rd_expect(2'd3, 8'h00, "R7 ctl reads enabled");
      // R3 other bits ignored when bit 7 low
      wr(2'd3, 8'h1F);
      oe_expect(24'hFFFFFF, "R3 dirs kept");
      rd_expect(2'd3, 8'h00, "R3 cfg unchanged");
      // C nibbles as inputs
      wr(2'd3, 8'h89);
      oe_expect(24'h000000, "R2 tristate 0x89");
      wr(2'd3, 8'h09);
      oe_expect(24'h00FFFF, "R4 C inputs");
      ext_en = 24'hFF00FF; ext_val = 24'h71005A;
      rd_expect(2'd2, 8'h71, "R6 C live");
      // A and B inputs, C out
      wr(2'd3, 8'h92);
      wr(2'd3, 8'h00);
      oe_expect(24'hFF0000, "R4 C only");
      rd_expect(2'd3, 8'h12, "R3 cfg kept 0x12");
      rd_expect(2'd1, 8'hFF, "R8 B pulled up");
      // R10 mode bits
      wr(2'd3, 8'hE4);
      wr(2'd3, 8'h00);
      oe_expect(24'hFFFFFF, "R10 mode bits no effect");
      rd_expect(2'd3, 8'h64, "R10 mode bits read back");
      // R9 port write and reads no side effect
      wr(2'd0, 8'h11);
      oe_expect(24'hFFFFFF, "R9 oe after port write");
      rd_expect(2'd0, 8'h11, "R1 A new value");
      for (int i = 0; i < 4; i++) rd_expect(2'(i), exp_rd(2'(i)), "R9 reads");
      oe_expect(24'hFFFFFF, "R9 oe after reads");
      // random traffic against the model
      for (int i = 0; i < 400; i++) begin
         ext_en  = $urandom;
         ext_val = $urandom;
         wr(2'($urandom_range(0, 3)), 8'($urandom));
      end
      // R8 reset mid-run
      @(posedge clk); #1 rst_n = 1'b0; model_on = 0;
      @(posedge clk); #1 rst_n = 1'b1; model_on = 1;
      rd_expect(2'd3, 8'h1B, "R8 ctl after second reset");
      oe_expect(24'h000000, "R8 oe after second reset");
      done = 1;
      summary();
   end

endmodule